// File: doc/BRIEF.md
# Dual-Array Translation Lookup

This block searches two translation arrays for a virtual address. The first array is indexed by set. All of its entries share one page size, which arrives on an input, and several ways sit behind each set. The second array is small and fully associative, and each of its entries records its own page size. Every entry covers a pair of neighbouring pages, one even and one odd. The stored virtual pair number therefore keeps address bits 47 down to 13, and it is shifted right by the page size before it is compared.

A lookup is presented for one cycle with an address and the current address-space identifier. One cycle later the block answers with hit or miss and a flat entry index. That index counts the set array first, by way and then by set, and places the fully associative entries after it. The set array has priority. The fully associative array supplies an answer only when no way of the selected set matches. A single write port loads any entry by its flat index.

Top module: `dual_tlb_lookup`

## Requirements
- R1: After reset `rsp_valid` and `rsp_hit` are 0 and every entry is empty, so any lookup misses until entries are written.
- R2: `rsp_valid` is 1 exactly in the cycle after a cycle with `lk_valid` high. The answer reflects the array contents and inputs of that lookup cycle.
- R3: An entry matches only if its enable bit is set and either its global bit is set or its stored ASID equals `lk_asid`.
- R4: The set array uses `stlb_ps` as page size. The selected set is the low log2(SETS) bits of `lk_va >> (stlb_ps+1)`. A hit in way w reports index w*SETS + set.
- R5: An entry's compare value is its 35-bit pair number (VA bits 47:13) shifted right by PS-12. It matches when it equals `lk_va >> (PS+1)`, so both pages of the pair hit the same entry.
- R6: When several ways of the selected set match, the lowest way wins. A set-array hit is reported even when a fully associative entry also matches.
- R7: The fully associative array answers only on a set-array miss. The lowest matching entry i wins, and it reports index WAYS*SETS + i.
- R8: Each fully associative entry uses its own stored page size both for its shift and for the address shift.
- R9: A write with `wr_en` high updates the entry at `wr_idx` at the clock edge. A lookup in the next cycle sees the new contents, and a lookup in the same cycle sees the old ones. `wr_ps` is stored only for fully associative entries.
- R10: On a miss, `rsp_hit` is 0 and `rsp_idx` is 0. When no lookup was made, `rsp_hit` is also 0.
- R11: A write whose `wr_idx` is WAYS*SETS+FA_ENTRIES or more changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_va | input | 48 | Virtual address to translate |
| lk_asid | input | 10 | Current address-space identifier |
| stlb_ps | input | 6 | Page size (log2 bytes) shared by the set array |
| wr_en | input | 1 | Write one entry |
| wr_idx | input | IDXW (7) | Flat index of the entry to write |
| wr_e | input | 1 | Enable bit to store |
| wr_g | input | 1 | Global bit to store |
| wr_asid | input | 10 | ASID to store |
| wr_vppn | input | 35 | Pair number, VA bits 47:13 |
| wr_ps | input | 6 | Page size, fully associative entries only |
| rsp_valid | output | 1 | Answer present |
| rsp_hit | output | 1 | Lookup matched an entry |
| rsp_idx | output | IDXW (7) | Flat index of the matching entry, 0 on miss |

## Verification
The bench probes the odd half of a page pair and addresses that share a set but differ in high bits. It also moves the shared page size so that one address falls into a different set. A design that drops the pair shift, or indexes with the wrong bits, would then miss pages it owns or hit pages it does not. It loads several ways and fully associative entries with the same pair and removes them one at a time, which shows up any inverted priority, any fallback that happens without a set miss, and any wrong index offset. It also places a write and a lookup in the same cycle and writes beyond the last entry. Both catch a write path that bypasses the register or wraps the index.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;
  localparam int VA_W     = 48;
  localparam int ASID_W   = 10;
  localparam int PS_W     = 6;
  localparam int PAIR_LSB = 13;
  localparam int VPPN_W   = VA_W - PAIR_LSB;

  typedef logic [VA_W-1:0]   va_t;
  typedef logic [VPPN_W-1:0] vppn_t;
  typedef logic [ASID_W-1:0] asid_t;
  typedef logic [PS_W-1:0]   ps_t;

  typedef struct packed {
    logic  e;
    logic  g;
    asid_t asid;
    vppn_t vppn;
  } set_ent_t;

  typedef struct packed {
    logic  e;
    logic  g;
    asid_t asid;
    vppn_t vppn;
    ps_t   ps;
  } fa_ent_t;

  // Pair number of an address: drop the page offset and the even/odd bit.
  function automatic va_t va_pair_num(va_t va, ps_t ps);
    return va >> (int'(ps) + 1);
  endfunction

  // Pair number held in an entry, aligned for a page size of 2**ps.
  function automatic va_t vppn_pair_num(vppn_t vppn, ps_t ps);
    va_t wide;
    int  sh;
    wide = va_t'(vppn);
    sh   = (int'(ps) >= PAIR_LSB - 1) ? int'(ps) + 1 - PAIR_LSB : 0;
    return wide >> sh;
  endfunction

  function automatic logic owner_ok(logic e, logic g, asid_t ent_asid, asid_t cur_asid);
    return e && (g || (ent_asid == cur_asid));
  endfunction
endpackage

// File: rtl/dtlb_first_hit.sv
module dtlb_first_hit #(
  parameter int N  = 4,
  parameter int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  hits,
  output logic          any,
  output logic [PW-1:0] pos
);
  always_comb begin
    any = 1'b0;
    pos = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) begin
        any = 1'b1;
        pos = PW'(i);
      end
    end
  end
endmodule

// File: rtl/dtlb_set_array.sv
module dtlb_set_array
  import dtlb_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  parameter int SETW = $clog2(SETS),
  parameter int WAYW = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [WAYW-1:0] wr_way,
  input  logic [SETW-1:0] wr_set,
  input  set_ent_t        wr_ent,
  input  logic [SETW-1:0] rd_set,
  input  va_t             va,
  input  asid_t           asid,
  input  ps_t             ps,
  output logic [WAYS-1:0] way_hits,
  output logic            any_hit,
  output logic [WAYW-1:0] hit_way
);
  va_t va_pair;
  assign va_pair = va_pair_num(va, ps);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    set_ent_t mem [SETS];
    set_ent_t cur;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < SETS; s++) mem[s] <= '0;
      end else if (wr_en && (wr_way == WAYW'(w))) begin
        mem[wr_set] <= wr_ent;
      end
    end

    assign cur = mem[rd_set];
    assign way_hits[w] = owner_ok(cur.e, cur.g, cur.asid, asid) &&
                         (vppn_pair_num(cur.vppn, ps) == va_pair);
  end

  dtlb_first_hit #(.N(WAYS), .PW(WAYW)) u_pick (
    .hits (way_hits),
    .any  (any_hit),
    .pos  (hit_way)
  );
endmodule

// File: rtl/dtlb_fa_array.sv
module dtlb_fa_array
  import dtlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int FAW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [FAW-1:0]     wr_sel,
  input  fa_ent_t            wr_ent,
  input  va_t                va,
  input  asid_t              asid,
  output logic [ENTRIES-1:0] ent_hits,
  output logic               any_hit,
  output logic [FAW-1:0]     hit_pos
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    fa_ent_t ent;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent <= '0;
      end else if (wr_en && (wr_sel == FAW'(i))) begin
        ent <= wr_ent;
      end
    end

    // Each entry applies its own page size to both sides of the compare.
    assign ent_hits[i] = owner_ok(ent.e, ent.g, ent.asid, asid) &&
                         (vppn_pair_num(ent.vppn, ent.ps) == va_pair_num(va, ent.ps));
  end

  dtlb_first_hit #(.N(ENTRIES), .PW(FAW)) u_pick (
    .hits (ent_hits),
    .any  (any_hit),
    .pos  (hit_pos)
  );
endmodule

// File: rtl/dual_tlb_lookup.sv
module dual_tlb_lookup
  import dtlb_pkg::*;
#(
  parameter int WAYS       = 4,
  parameter int SETS       = 16,
  parameter int FA_ENTRIES = 8,
  localparam int IDXW      = $clog2(WAYS * SETS + FA_ENTRIES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  input  logic [47:0]     lk_va,
  input  logic [9:0]      lk_asid,
  input  logic [5:0]      stlb_ps,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic            wr_e,
  input  logic            wr_g,
  input  logic [9:0]      wr_asid,
  input  logic [34:0]     wr_vppn,
  input  logic [5:0]      wr_ps,
  output logic            rsp_valid,
  output logic            rsp_hit,
  output logic [IDXW-1:0] rsp_idx
);
  localparam int SETW      = $clog2(SETS);
  localparam int WAYW      = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int FAW       = (FA_ENTRIES > 1) ? $clog2(FA_ENTRIES) : 1;
  localparam int SET_TOTAL = WAYS * SETS;
  localparam int TOTAL     = SET_TOTAL + FA_ENTRIES;

  // Write decode: flat index -> (way, set) or fully associative slot.
  logic            wr_to_set;
  logic            wr_to_fa;
  logic [WAYW-1:0] wr_way;
  logic [SETW-1:0] wr_set;
  logic [FAW-1:0]  wr_fa;
  set_ent_t        wr_set_ent;
  fa_ent_t         wr_fa_ent;

  assign wr_to_set  = wr_en && (int'(wr_idx) < SET_TOTAL);
  assign wr_to_fa   = wr_en && (int'(wr_idx) >= SET_TOTAL) && (int'(wr_idx) < TOTAL);
  assign wr_way     = WAYW'(int'(wr_idx) / SETS);
  assign wr_set     = SETW'(int'(wr_idx) % SETS);
  assign wr_fa      = FAW'(int'(wr_idx) - SET_TOTAL);
  assign wr_set_ent = '{e: wr_e, g: wr_g, asid: wr_asid, vppn: wr_vppn};
  assign wr_fa_ent  = '{e: wr_e, g: wr_g, asid: wr_asid, vppn: wr_vppn, ps: wr_ps};

  // Lookup side.
  logic [SETW-1:0]       lk_set;
  logic [WAYS-1:0]       set_way_hits;
  logic                  set_any_hit;
  logic [WAYW-1:0]       set_way;
  logic [FA_ENTRIES-1:0] fa_ent_hits;
  logic                  fa_any_hit;
  logic [FAW-1:0]        fa_pos;

  assign lk_set = SETW'(va_pair_num(lk_va, stlb_ps));

  dtlb_set_array #(.WAYS(WAYS), .SETS(SETS), .SETW(SETW), .WAYW(WAYW)) u_set (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_to_set),
    .wr_way   (wr_way),
    .wr_set   (wr_set),
    .wr_ent   (wr_set_ent),
    .rd_set   (lk_set),
    .va       (lk_va),
    .asid     (lk_asid),
    .ps       (stlb_ps),
    .way_hits (set_way_hits),
    .any_hit  (set_any_hit),
    .hit_way  (set_way)
  );

  dtlb_fa_array #(.ENTRIES(FA_ENTRIES), .FAW(FAW)) u_fa (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_to_fa),
    .wr_sel   (wr_fa),
    .wr_ent   (wr_fa_ent),
    .va       (lk_va),
    .asid     (lk_asid),
    .ent_hits (fa_ent_hits),
    .any_hit  (fa_any_hit),
    .hit_pos  (fa_pos)
  );

  // Merge: set array first, fully associative array as fallback.
  logic [IDXW-1:0] set_flat;
  logic [IDXW-1:0] fa_flat;
  logic            nxt_hit;
  logic [IDXW-1:0] nxt_idx;

  assign set_flat = IDXW'(int'(set_way) * SETS + int'(lk_set));
  assign fa_flat  = IDXW'(SET_TOTAL + int'(fa_pos));
  assign nxt_hit  = lk_valid && (set_any_hit || fa_any_hit);

  always_comb begin
    nxt_idx = '0;
    if (lk_valid) begin
      if (set_any_hit)     nxt_idx = set_flat;
      else if (fa_any_hit) nxt_idx = fa_flat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_idx   <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= nxt_hit;
      rsp_idx   <= nxt_idx;
    end
  end
endmodule

// File: rtl/dual_tlb_lookup_chk.sv
module dual_tlb_lookup_chk #(
  parameter int SET_TOTAL = 64,
  parameter int TOTAL     = 72,
  parameter int IDXW      = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lk_valid,
  input logic            set_any_hit,
  input logic            fa_any_hit,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic [IDXW-1:0] rsp_idx
);
  AST_RSP_TRACKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (rsp_valid == $past(lk_valid))); // R2

  AST_HIT_NEEDS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid); // R10

  AST_MISS_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_idx == '0)); // R10

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (int'(rsp_idx) < TOTAL)); // R7

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && set_any_hit) |=> (rsp_hit && (int'(rsp_idx) < SET_TOTAL))); // R6

  AST_FA_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !set_any_hit && fa_any_hit) |=> (rsp_hit && (int'(rsp_idx) >= SET_TOTAL))); // R7

  AST_NO_MATCH_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !set_any_hit && !fa_any_hit) |=> !rsp_hit); // R3
endmodule

bind dual_tlb_lookup dual_tlb_lookup_chk #(
  .SET_TOTAL (WAYS * SETS),
  .TOTAL     (WAYS * SETS + FA_ENTRIES),
  .IDXW      (IDXW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lk_valid    (lk_valid),
  .set_any_hit (set_any_hit),
  .fa_any_hit  (fa_any_hit),
  .rsp_valid   (rsp_valid),
  .rsp_hit     (rsp_hit),
  .rsp_idx     (rsp_idx)
);

// File: tb/dual_tlb_lookup_tb_top.sv
`timescale 1ns/1ps
module dual_tlb_lookup_tb_top;
  localparam int WAYS   = 4;
  localparam int SETS   = 16;
  localparam int FA_N   = 8;
  localparam int SET_T  = WAYS * SETS;
  localparam int TOTAL  = SET_T + FA_N;
  localparam int IDXW   = $clog2(TOTAL);
  localparam longint VA_MASK = 64'h0000_FFFF_FFFF_FFFF;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            lk_valid = 1'b0;
  logic [47:0]     lk_va = '0;
  logic [9:0]      lk_asid = '0;
  logic [5:0]      stlb_ps = 6'd12;
  logic            wr_en = 1'b0;
  logic [IDXW-1:0] wr_idx = '0;
  logic            wr_e = 1'b0;
  logic            wr_g = 1'b0;
  logic [9:0]      wr_asid = '0;
  logic [34:0]     wr_vppn = '0;
  logic [5:0]      wr_ps = '0;
  logic            rsp_valid;
  logic            rsp_hit;
  logic [IDXW-1:0] rsp_idx;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dual_tlb_lookup #(.WAYS(WAYS), .SETS(SETS), .FA_ENTRIES(FA_N)) dut_i (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va), .lk_asid(lk_asid),
    .stlb_ps(stlb_ps), .wr_en(wr_en), .wr_idx(wr_idx), .wr_e(wr_e), .wr_g(wr_g),
    .wr_asid(wr_asid), .wr_vppn(wr_vppn), .wr_ps(wr_ps),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_idx(rsp_idx)
  );

  // Behavioural model: flat entry list.
  bit     m_e    [TOTAL];
  bit     m_g    [TOTAL];
  int     m_asid [TOTAL];
  longint m_vppn [TOTAL];
  int     m_ps   [TOTAL];

  function automatic longint pair_of(longint va);
    return (va & VA_MASK) >>> 13;
  endfunction

  function automatic int set_of(longint va, int ps);
    return int'(((va & VA_MASK) / (longint'(1) << (ps + 1))) % SETS);
  endfunction

  // Same pair when the address bits above the pair offset agree.
  function automatic bit covers(int f, longint va, int asid, int ps);
    longint keep;
    keep = ~((longint'(1) << (ps + 1)) - 1) & VA_MASK;
    if (!m_e[f]) return 1'b0;
    if (!m_g[f] && (m_asid[f] != asid)) return 1'b0;
    return (((m_vppn[f] << 13) & keep) == (va & keep));
  endfunction

  function automatic void model_lookup(input longint va, input int asid, input int gps,
                                       output bit hit, output int idx);
    hit = 1'b0;
    idx = 0;
    for (int w = 0; w < WAYS; w++) begin
      int f;
      f = w * SETS + set_of(va, gps);
      if (!hit && covers(f, va, asid, gps)) begin
        hit = 1'b1;
        idx = f;
      end
    end
    for (int i = 0; i < FA_N; i++) begin
      if (!hit && covers(SET_T + i, va, asid, m_ps[SET_T + i])) begin
        hit = 1'b1;
        idx = SET_T + i;
      end
    end
  endfunction

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // One clock: expectation from pre-edge state, model write after the edge,
  // compare at the following falling edge.
  task automatic tick(input string tag);
    bit ev;
    bit eh;
    int ei;
    ev = lk_valid;
    model_lookup(longint'(lk_va), int'(lk_asid), int'(stlb_ps), eh, ei);
    if (!ev) begin
      eh = 1'b0;
      ei = 0;
    end
    @(posedge clk);
    if (wr_en && (int'(wr_idx) < TOTAL)) begin
      m_e[wr_idx]    = wr_e;
      m_g[wr_idx]    = wr_g;
      m_asid[wr_idx] = int'(wr_asid);
      m_vppn[wr_idx] = longint'(wr_vppn);
      m_ps[wr_idx]   = int'(wr_ps);
    end
    @(negedge clk);
    chk("R2", "rsp_valid", longint'(rsp_valid), longint'(ev));
    chk(eh ? tag : "R10", "rsp_hit", longint'(rsp_hit), longint'(eh));
    chk(eh ? tag : "R10", "rsp_idx", longint'(rsp_idx), longint'(ei));
  endtask

  task automatic cyc(input bit lv, input longint va, input int asid,
                     input bit we, input int idx, input bit e, input bit g,
                     input int wasid, input longint vppn, input int wps, input string tag);
    lk_valid = lv;
    lk_va    = va[47:0];
    lk_asid  = 10'(asid);
    wr_en    = we;
    wr_idx   = IDXW'(idx);
    wr_e     = e;
    wr_g     = g;
    wr_asid  = 10'(wasid);
    wr_vppn  = 35'(vppn);
    wr_ps    = 6'(wps);
    tick(tag);
  endtask

  task automatic look(input longint va, input int asid, input string tag);
    cyc(1'b1, va, asid, 1'b0, 0, 1'b0, 1'b0, 0, 0, 0, tag);
  endtask

  task automatic put(input int idx, input bit e, input bit g, input int asid,
                     input longint va, input int ps, input string tag);
    cyc(1'b0, 0, 0, 1'b1, idx, e, g, asid, pair_of(va), ps, tag);
  endtask

  initial begin
    for (int i = 0; i < TOTAL; i++) begin
      m_e[i] = 0; m_g[i] = 0; m_asid[i] = 0; m_vppn[i] = 0; m_ps[i] = 0;
    end
    repeat (3) @(negedge clk);
    chk("R1", "rsp_valid in reset", longint'(rsp_valid), 0);
    chk("R1", "rsp_hit in reset", longint'(rsp_hit), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "rsp_valid after reset", longint'(rsp_valid), 0);
    look(48'h0000_1234_5000, 5, "R1");
    look(48'h0000_0000_0000, 0, "R1");

    begin
      longint a;
      a = 64'h0000_1234_5000;
      stlb_ps = 6'd12;
      // Write and lookup in the same cycle: old contents answer.
      cyc(1'b1, a, 5, 1'b1, set_of(a, 12), 1'b1, 1'b0, 5, pair_of(a), 0, "R9");
      look(a, 5, "R9");
      chk("R4", "index way0", longint'(rsp_idx), longint'(set_of(a, 12)));
      look(a + 64'h1000, 5, "R5");
      look(a ^ (longint'(1) << 40), 5, "R5");
      look(a + 64'h2000, 5, "R5");
      look(a, 6, "R3");
      put(set_of(a, 12), 1'b1, 1'b1, 5, a, 0, "R3");
      look(a, 6, "R3");
      put(set_of(a, 12), 1'b0, 1'b1, 5, a, 0, "R3");
      look(a, 5, "R3");
    end

    begin
      longint b;
      b = 64'h0000_7777_A000;
      put(2 * SETS + set_of(b, 12), 1'b1, 1'b0, 3, b, 0, "R6");
      put(1 * SETS + set_of(b, 12), 1'b1, 1'b0, 3, b, 0, "R6");
      look(b, 3, "R6");
      chk("R6", "lowest way", longint'(rsp_idx), longint'(SETS + set_of(b, 12)));
      put(SET_T + 0, 1'b1, 1'b0, 3, b, 12, "R6");
      look(b, 3, "R6");
      put(1 * SETS + set_of(b, 12), 1'b0, 1'b0, 3, b, 0, "R6");
      put(2 * SETS + set_of(b, 12), 1'b0, 1'b0, 3, b, 0, "R6");
      look(b + 64'h1000, 3, "R7");
      chk("R7", "fa index", longint'(rsp_idx), longint'(SET_T));
    end

    begin
      longint c;
      c = 64'h0000_4000_0000;
      put(SET_T + 5, 1'b1, 1'b1, 0, c, 21, "R8");
      put(SET_T + 3, 1'b1, 1'b1, 0, c + 64'h0012_3000, 21, "R8");
      look(c + 64'h003F_F000, 9, "R8");
      chk("R7", "lowest fa", longint'(rsp_idx), longint'(SET_T + 3));
      look(c + 64'h0040_0000, 9, "R8");
      look(c - 64'h1000, 9, "R8");
    end

    begin
      longint d;
      d = 64'h0000_0AB0_2000;
      stlb_ps = 6'd13;
      put(3 * SETS + set_of(d, 13), 1'b1, 1'b0, 7, d, 0, "R4");
      look(d, 7, "R4");
      look(d + 64'h1000, 7, "R4");
      look(d - 64'h2000, 7, "R5");
      stlb_ps = 6'd12;
      look(d, 7, "R4");
      stlb_ps = 6'd13;
    end

    begin
      longint x;
      x = 64'h0000_5555_0000;
      put(100, 1'b1, 1'b1, 0, x, 12, "R11");
      look(x, 0, "R11");
      put(TOTAL, 1'b1, 1'b1, 0, x, 12, "R11");
      look(x, 0, "R11");
    end

    begin
      longint pool [4];
      int lf;
      pool[0] = 64'h0000_0010_0000;
      pool[1] = 64'h0000_0010_2000;
      pool[2] = 64'h0000_8000_4000;
      pool[3] = 64'h0000_0010_0000 + (longint'(1) << 44);
      lf = 32'h1ACE;
      for (int k = 0; k < 300; k++) begin
        int ix;
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]} ^ (k * 7 + 1);
        stlb_ps = (lf[9]) ? 6'd13 : 6'd12;
        ix = (lf[4:3] == 2'b00) ? SET_T + int'(lf[14:12])
                                : int'(lf[5:4]) * SETS + set_of(pool[lf[11:10]], int'(stlb_ps));
        cyc(lf[2], pool[lf[7:6]] + longint'(lf[8]) * 64'h1000, int'(lf[1:0]),
            lf[13] | lf[15], ix, lf[16] | lf[17], lf[18] & lf[19], int'(lf[21:20]),
            pair_of(pool[lf[11:10]]), 12 + int'(lf[22]), "R3");
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end
endmodule